// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This unit gives a processor core two timers that advance together on a shared tick enable. The first is a free-running 64-bit time base that counts up. The second is a 32-bit signed decrementer that counts down. When the decrementer expires, the unit raises an interrupt request. The request stays up until the core acknowledges it.

Software reaches both counters through a small register port with a 2-bit address. Writes take effect at the clock edge. Reads return the current count combinationally. The time base is read and written as two 32-bit halves. Loading the decrementer re-arms its expiry. Two loads are handled as special cases:

- A negative value loaded over a non-negative one fires on the very next tick.
- A negative value loaded over a negative one raises nothing.

Top module: `tbdec_timer`

## Requirements
- R1: After reset the time base and the decrementer are both zero, no expiry is armed and `irq` is low.
- R2: On every cycle with `tick_en` high and no time base write, the 64-bit time base increments by one, carrying from the low half into the high half. With `tick_en` low it holds.
- R3: A write to address 0 loads the low 32 bits of the time base, and a write to address 1 loads the high 32 bits. The other half keeps its value. In the cycle of such a write the time base is not incremented.
- R4: On every tick the decrementer drops by one and wraps past zero into negative values. A write to address 2 loads it instead, and that write wins over a tick in the same cycle.
- R5: `rd_data` returns, for `addr` 0, 1, 2 and 3 respectively: time base bits 31:0, time base bits 63:32, the decrementer, and zero.
- R6: Loading a non-negative value N ≥ 1 sets `irq` after the Nth following tick and not before. A load of N = 0 behaves like N = 1.
- R7: Loading a negative value while the decrementer holds a non-negative value sets `irq` after the next tick.
- R8: Loading a negative value while the decrementer is already negative raises no interrupt, however many ticks follow.
- R9: Any decrementer write cancels an armed expiry that has not yet fired. Only the newly loaded value decides the next expiry.
- R10: `irq` is a level that stays high, across idle cycles and further ticks, until `irq_ack` is asserted. It reads low in the same cycle as `irq_ack`, and it stays low after that cycle.
- R11: One load produces at most one interrupt. After the interrupt is acknowledged, further ticks do not raise it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances both counters by one count in each cycle it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select for both read and write: 0 time base low, 1 time base high, 2 decrementer |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Core accepts the interrupt |

## Verification
Counter loads and tick updates show on `rd_data` after the edge that samples them. The bench drives each stimulus 1 ns after a rising edge and reads back 1 ns after the next edge. An expiry raises `irq` one edge after the expiring tick, so expiry checks look at `irq` just before and just after that tick. The acknowledge acts combinationally, so the bench checks `irq` 1 ns after raising `irq_ack`, before the clearing edge, and again after it.

// File: rtl/tbdec_timer.sv
module tbdec_timer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          irq,
  input  logic          irq_ack
);
  localparam int TW = 2 * DW;
  localparam logic signed [DW-1:0] ONE = DW'(1);

  logic [TW-1:0]        tb_q;
  logic signed [DW-1:0] dec_q;
  logic                 armed_q;
  logic                 pend_q;

  wire wr_lo  = wr_en && addr == 2'd0;
  wire wr_hi  = wr_en && addr == 2'd1;
  wire wr_dec = wr_en && addr == 2'd2;
  wire expire = tick_en && !wr_dec && armed_q && (dec_q <= ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else if (wr_lo) begin
      tb_q[DW-1:0] <= wr_data;
    end else if (wr_hi) begin
      tb_q[TW-1:DW] <= wr_data;
    end else if (tick_en) begin
      tb_q <= tb_q + TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_q   <= '0;
      armed_q <= 1'b0;
    end else if (wr_dec) begin
      dec_q   <= wr_data;
      armed_q <= !wr_data[DW-1] || !dec_q[DW-1];
    end else begin
      if (tick_en) dec_q <= dec_q - ONE;
      if (expire)  armed_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= expire || (pend_q && !irq_ack);
  end

  assign irq = pend_q && !irq_ack;

  always_comb begin
    case (addr)
      2'd0:    rd_data = tb_q[DW-1:0];
      2'd1:    rd_data = tb_q[TW-1:DW];
      2'd2:    rd_data = dec_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tbdec_timer_chk.sv
module tbdec_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [DW-1:0] rd_data,
  input logic          irq,
  input logic          irq_ack,
  input logic [2*DW-1:0] tb_q,
  input logic [DW-1:0] dec_q,
  input logic          pend_q
);
  localparam int TW = 2 * DW;
  wire tb_wr  = wr_en && (addr == 2'd0 || addr == 2'd1);
  wire dec_wr = wr_en && addr == 2'd2;

  assert_tb_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !tb_wr) |=> tb_q == $past(tb_q) + TW'(1));

  assert_tb_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !tb_wr) |=> $stable(tb_q));

  assert_dec_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_wr) |=> dec_q == $past(dec_q) - DW'(1));

  assert_rd_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd2) |-> rd_data == dec_q);

  assert_fire_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !$rose(pend_q));

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !irq);

  assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !irq_ack) |=> pend_q);
endmodule

bind tbdec_timer tbdec_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
  .rd_data(rd_data), .irq(irq), .irq_ack(irq_ack), .tb_q(tb_q),
  .dec_q(dec_q), .pend_q(pend_q)
);

// File: tb/tb_tbdec_timer.sv
module tb_tbdec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        irq_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tbdec_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq), .irq_ack(irq_ack)
  );

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic tick(input int n);
    tick_en = 1'b1;
    repeat (n) cyc();
    tick_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic t);
    addr = a; wr_data = d; wr_en = 1'b1; tick_en = t;
    cyc();
    wr_en = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #0.5; v = rd_data;
  endtask

  task automatic ack_irq(input string tag);
    irq_ack = 1'b1; #0.5;
    chk(irq, 1'b0, tag);
    cyc();
    irq_ack = 1'b0; #0.5;
    chk(irq, 1'b0, tag);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk(v, 0, "R1 tb low");
    rd(2'd1, v); chk(v, 0, "R1 tb high");
    rd(2'd2, v); chk(v, 0, "R1 dec");
    chk(irq, 1'b0, "R1 irq");
    rd(2'd3, v); chk(v, 0, "R5 unused addr");
  endtask

  task automatic t_timebase();
    logic [31:0] v;
    tick(5);
    rd(2'd0, v); chk(v, 5, "R2 tb after 5 ticks");
    repeat (3) cyc();
    rd(2'd0, v); chk(v, 5, "R2 tb holds");
    wr(2'd1, 32'h1, 1'b1);
    wr(2'd0, 32'hFFFF_FFFE, 1'b1);
    rd(2'd0, v); chk(v, 32'hFFFF_FFFE, "R3 low load no tick");
    rd(2'd1, v); chk(v, 32'h1, "R3 high load no tick");
    tick(3);
    rd(2'd1, v); chk(v, 32'h2, "R2 carry high");
    rd(2'd0, v); chk(v, 32'h1, "R2 carry low");
  endtask

  task automatic t_dec_count();
    logic [31:0] v;
    wr(2'd2, 32'd10, 1'b1);
    rd(2'd2, v); chk(v, 10, "R4 write beats tick");
    tick(4);
    rd(2'd2, v); chk(v, 6, "R4 counts down");
    repeat (2) cyc();
    rd(2'd2, v); chk(v, 6, "R4 holds");
  endtask

  task automatic t_expire();
    logic [31:0] v;
    wr(2'd2, 32'd3, 1'b0);
    tick(2);
    chk(irq, 1'b0, "R6 not before Nth tick");
    tick(1);
    chk(irq, 1'b1, "R6 fires after Nth tick");
    repeat (3) cyc();
    chk(irq, 1'b1, "R10 held while idle");
    tick(2);
    chk(irq, 1'b1, "R10 held over ticks");
    ack_irq("R10 ack clears");
    tick(4);
    chk(irq, 1'b0, "R11 no refire");
    rd(2'd2, v); chk(v, 32'hFFFF_FFFA, "R4 wraps negative");
  endtask

  task automatic t_zero();
    wr(2'd2, 32'd0, 1'b0);
    chk(irq, 1'b0, "R6 zero load no immediate irq");
    tick(1);
    chk(irq, 1'b1, "R6 zero fires first tick");
    ack_irq("R10 ack zero");
  endtask

  task automatic t_neg_flip();
    logic [31:0] v;
    wr(2'd2, 32'd5, 1'b0);
    wr(2'd2, 32'hFFFF_FFFE, 1'b0);
    chk(irq, 1'b0, "R7 waits for tick");
    tick(1);
    chk(irq, 1'b1, "R7 sign flip fires");
    ack_irq("R10 ack flip");
    rd(2'd2, v); chk(v, 32'hFFFF_FFFD, "R7 dec after flip");
  endtask

  task automatic t_neg_neg();
    logic [31:0] v;
    wr(2'd2, 32'hFFFF_FFF7, 1'b0);
    tick(20);
    chk(irq, 1'b0, "R8 neg over neg silent");
    rd(2'd2, v); chk(v, 32'hFFFF_FFE3, "R8 dec value");
  endtask

  task automatic t_cancel();
    wr(2'd2, 32'd4, 1'b0);
    tick(2);
    wr(2'd2, 32'd10, 1'b0);
    tick(3);
    chk(irq, 1'b0, "R9 old expiry cancelled");
    tick(6);
    chk(irq, 1'b0, "R9 not early");
    tick(1);
    chk(irq, 1'b1, "R9 new expiry fires");
    ack_irq("R10 ack cancel");
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    t_reset();
    t_timebase();
    t_dec_count();
    t_expire();
    t_zero();
    t_neg_flip();
    t_neg_neg();
    t_cancel();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule